// File: doc/BRIEF.md
# Source Operand Fetch Unit

This block turns the source part of a decoded instruction into an operand value. It takes a 4-bit source register number, a 2-bit mode field and a byte/word flag. It then reads the register file, fetches an extension word when the mode needs one, reads data memory through a word-wide port and writes back any register that the mode advances. The result is returned as one operand word, with a one-cycle valid pulse and a count of the extension words consumed. The decoder and the execute stage sit around it.

Register 3 with any mode and register 2 with modes 2 and 3 are not real registers here. They yield fixed constants with no memory traffic. Register 2 with mode 1 gives absolute addressing, with a zero base. Register 0 is the program counter. Indexed mode on it is PC-relative, and auto-increment on it fetches an immediate word. A new request is accepted in any cycle in which the unit is idle, and that includes the cycle in which the previous result is valid.

Top module: `src_operand_fetch`

## Requirements
- R1: Mode 0 on any register other than 3 returns that register's content. `opValid` rises on the clock edge after the request, with no memory request and `extWords` = 0.
- R2: Register 3 with modes 0/1/2/3 yields 0, 1, 2 and all ones. Register 2 with modes 2/3 yields 4 and 8. Both complete like R1, with no memory request and `extWords` = 0.
- R3: Mode 1 on registers 1 and 4 to 15 (indexed) reads the extension word at the PC and advances the PC by 2. It then returns the data at extension + register, with `extWords` = 1.
- R4: Mode 1 on register 0 (PC-relative) uses as its base the address of the extension word itself, which is the PC before the advance.
- R5: Mode 1 on register 2 (absolute) uses the extension word itself as the data address. The PC advances by 2 and `extWords` = 1.
- R6: Mode 2 (indirect) returns the data at the address held in the register, leaves that register unchanged and gives `extWords` = 0.
- R7: Mode 3 on registers other than 0 (auto-increment) returns the data at the register's address. It then adds 1 to that register for a byte operation or 2 for a word operation, with `extWords` = 0.
- R8: Mode 3 on register 0 (immediate) returns the word at the PC and advances the PC by 2, even for a byte operation, with `extWords` = 1.
- R9: `memAddr` always has bit 0 clear. A byte read at an odd address returns bits 15:8 of the word, and at an even address bits 7:0.
- R10: With `byteOp` = 1, every result (register, constant or memory) is the selected byte zero-extended to 16 bits.
- R11: After reset `opValid`, `memReq` and `rfWrEn` are low. `opValid` is a single-cycle pulse per request. Memory wait states, where `memAck` is held low, stall the unit without loss of data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a source operand; taken while idle |
| srcReg | input | 4 | Source register number |
| srcMode | input | 2 | Source addressing mode |
| byteOp | input | 1 | 1 = byte operation, 0 = word |
| rfRdIdx | output | 4 | Register file read index |
| rfRdData | input | 16 | Register file read data (combinational) |
| rfWrEn | output | 1 | Register file write strobe |
| rfWrIdx | output | 4 | Register file write index |
| rfWrData | output | 16 | Register file write data |
| memReq | output | 1 | Memory read request, held until acknowledged |
| memAddr | output | 16 | Byte address of the word read, bit 0 clear |
| memRdata | input | 16 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory read complete |
| opValid | output | 1 | Operand valid pulse |
| opData | output | 16 | Operand value |
| extWords | output | 2 | Extension words consumed by this operand |

## Verification
A stuck or misrouted state would show at the ports within a few cycles. A wrong read index shows up as the wrong operand on the next `opValid`. A wrong write-back shows in the PC or pointer register straight after the memory acknowledge. A lost acknowledge shows as an `opValid` that never comes. The bench therefore compares the register file after every operand, not just the operand value. It also drives the memory paths with wait states, so that a strobe sampled in the wrong cycle shows up as a wrong or repeated register update.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] PC_IDX = 4'd0;
  localparam logic [IDX_W-1:0] SR_IDX = 4'd2;
  localparam logic [IDX_W-1:0] CG_IDX = 4'd3;

  typedef enum logic [2:0] {K_REG, K_CONST, K_INDEX, K_ABS, K_IND, K_AUTO} kind_t;
  typedef enum logic [1:0] {S_IDLE, S_EXT, S_BASE, S_DATA} state_t;
  typedef enum logic [1:0] {RD_IN, RD_PC, RD_HELD} rdSel_t;

  typedef struct packed {
    logic   capField;
    logic   capDirect;
    logic   capPtr;
    logic   capExt;
    logic   capBase;
    logic   capData;
    rdSel_t rdSel;
    logic   memReq;
    logic   memUseAddr;
    logic   wrPc;
    logic   wrPtr;
  } strobe_t;

  function automatic kind_t classify(input logic [IDX_W-1:0] r, input logic [1:0] m);
    kind_t k;
    if (r == CG_IDX)                 k = K_CONST;
    else if (r == SR_IDX && m[1])    k = K_CONST;
    else begin
      case (m)
        2'd0:    k = K_REG;
        2'd1:    k = (r == SR_IDX) ? K_ABS : K_INDEX;
        2'd2:    k = K_IND;
        default: k = K_AUTO;
      endcase
    end
    return k;
  endfunction

  function automatic logic usesExt(input logic [IDX_W-1:0] r, input logic [1:0] m);
    kind_t k;
    k = classify(r, m);
    return (k == K_INDEX) || (k == K_ABS) || (k == K_AUTO && r == PC_IDX);
  endfunction
endpackage

// File: rtl/sof_ctrl.sv
module sof_ctrl
  import sof_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  kind_t   startKind,
  input  logic    memAck,
  output strobe_t stb,
  output logic    idle
);
  state_t state, nextState;
  kind_t  kindQ;

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_HELD;
    nextState = state;
    case (state)
      S_IDLE: begin
        stb.rdSel = RD_IN;
        if (startReq) begin
          stb.capField = 1'b1;
          case (startKind)
            K_REG, K_CONST: stb.capDirect = 1'b1;
            K_INDEX, K_ABS: nextState = S_EXT;
            default: begin
              stb.capPtr = 1'b1;
              nextState  = S_DATA;
            end
          endcase
        end
      end
      S_EXT: begin
        stb.rdSel  = RD_PC;
        stb.memReq = 1'b1;
        if (memAck) begin
          stb.capExt = 1'b1;
          stb.wrPc   = 1'b1;
          nextState  = S_BASE;
        end
      end
      S_BASE: begin
        stb.capBase = 1'b1;
        nextState   = S_DATA;
      end
      default: begin
        stb.memReq     = 1'b1;
        stb.memUseAddr = 1'b1;
        if (memAck) begin
          stb.capData = 1'b1;
          stb.wrPtr   = (kindQ == K_AUTO);
          nextState   = S_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= K_REG;
    end else begin
      state <= nextState;
      if (stb.capField) kindQ <= startKind;
    end
  end

  assign idle = (state == S_IDLE);
endmodule

// File: rtl/sof_datapath.sv
module sof_datapath
  import sof_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  srcReg,
  input  logic [1:0]        srcMode,
  input  logic              byteOp,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRdata,
  output kind_t             startKind,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic              rfWrEn,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  output logic              opValid,
  output logic [DATA_W-1:0] opData,
  output logic [EXT_W-1:0]  extWords
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);
  localparam logic [DATA_W-1:0] BYTE_STEP = DATA_W'(1);

  logic [IDX_W-1:0]  regQ;
  logic              byteQ;
  logic              extFlagQ;
  logic [DATA_W-1:0] addrQ, extQ, pcSaveQ;
  logic              opValidQ;
  logic [DATA_W-1:0] opDataQ;
  logic [EXT_W-1:0]  extWordsQ;

  logic [DATA_W-1:0] cgVal, directRaw, directVal, baseVal, stepVal, memPick;
  logic [HALF-1:0]   laneByte;

  assign startKind = classify(srcReg, srcMode);

  always_comb begin
    case (stb.rdSel)
      RD_IN:   rfRdIdx = srcReg;
      RD_PC:   rfRdIdx = PC_IDX;
      default: rfRdIdx = regQ;
    endcase
  end

  always_comb begin
    if (srcReg == CG_IDX) begin
      case (srcMode)
        2'd0:    cgVal = '0;
        2'd1:    cgVal = DATA_W'(1);
        2'd2:    cgVal = DATA_W'(2);
        default: cgVal = '1;
      endcase
    end else begin
      cgVal = srcMode[0] ? DATA_W'(8) : DATA_W'(4);
    end
  end

  assign directRaw = (startKind == K_CONST) ? cgVal : rfRdData;
  assign directVal = byteOp ? {{(DATA_W-HALF){1'b0}}, directRaw[HALF-1:0]} : directRaw;

  always_comb begin
    if (regQ == PC_IDX)      baseVal = pcSaveQ;
    else if (regQ == SR_IDX) baseVal = '0;
    else                     baseVal = rfRdData;
  end

  assign stepVal  = (byteQ && regQ != PC_IDX) ? BYTE_STEP : WORD_STEP;
  assign laneByte = addrQ[0] ? memRdata[DATA_W-1:HALF] : memRdata[HALF-1:0];
  assign memPick  = byteQ ? {{(DATA_W-HALF){1'b0}}, laneByte} : memRdata;

  assign memReq   = stb.memReq;
  assign memAddr  = stb.memUseAddr ? {addrQ[DATA_W-1:1], 1'b0} : {rfRdData[DATA_W-1:1], 1'b0};
  assign rfWrEn   = stb.wrPc | stb.wrPtr;
  assign rfWrIdx  = stb.wrPc ? PC_IDX : regQ;
  assign rfWrData = stb.wrPc ? (rfRdData + WORD_STEP) : (addrQ + stepVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regQ      <= '0;
      byteQ     <= 1'b0;
      extFlagQ  <= 1'b0;
      addrQ     <= '0;
      extQ      <= '0;
      pcSaveQ   <= '0;
      opValidQ  <= 1'b0;
      opDataQ   <= '0;
      extWordsQ <= '0;
    end else begin
      opValidQ <= stb.capDirect | stb.capData;
      if (stb.capField) begin
        regQ     <= srcReg;
        byteQ    <= byteOp;
        extFlagQ <= usesExt(srcReg, srcMode);
      end
      if (stb.capPtr) addrQ <= rfRdData;
      if (stb.capExt) begin
        extQ    <= memRdata;
        pcSaveQ <= rfRdData;
      end
      if (stb.capBase) addrQ <= extQ + baseVal;
      if (stb.capDirect) begin
        opDataQ   <= directVal;
        extWordsQ <= '0;
      end
      if (stb.capData) begin
        opDataQ   <= memPick;
        extWordsQ <= EXT_W'(extFlagQ);
      end
    end
  end

  assign opValid  = opValidQ;
  assign opData   = opDataQ;
  assign extWords = extWordsQ;
endmodule

// File: rtl/src_operand_fetch.sv
module src_operand_fetch
  import sof_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [3:0]        srcReg,
  input  logic [1:0]        srcMode,
  input  logic              byteOp,
  output logic [3:0]        rfRdIdx,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [3:0]        rfWrIdx,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              opValid,
  output logic [DATA_W-1:0] opData,
  output logic [EXT_W-1:0]  extWords
);
  strobe_t stb;
  kind_t   startKind;
  logic    ctlIdle;

  sof_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startKind(startKind),
    .memAck(memAck), .stb(stb), .idle(ctlIdle)
  );

  sof_datapath #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .srcReg(srcReg), .srcMode(srcMode),
    .byteOp(byteOp), .rfRdData(rfRdData), .memRdata(memRdata),
    .startKind(startKind), .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .memReq(memReq),
    .memAddr(memAddr), .opValid(opValid), .opData(opData), .extWords(extWords)
  );
endmodule

// File: rtl/sof_chk.sv
module sof_chk #(
  parameter int DATA_W = 16,
  parameter int EXT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlIdle,
  input logic              startReq,
  input logic [3:0]        srcReg,
  input logic [1:0]        srcMode,
  input logic [3:0]        rfRdIdx,
  input logic [DATA_W-1:0] rfRdData,
  input logic              rfWrEn,
  input logic [3:0]        rfWrIdx,
  input logic [DATA_W-1:0] rfWrData,
  input logic              memReq,
  input logic [DATA_W-1:0] memAddr,
  input logic              memAck,
  input logic              opValid,
  input logic [EXT_W-1:0]  extWords
);
  // R9
  mem_addr_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[0] == 1'b0));

  // R1
  reg_mode_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlIdle && startReq && srcMode == 2'd0 && srcReg != 4'd3) |=> (opValid && extWords == '0));

  // R2
  const_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlIdle && startReq && srcReg == 4'd3) |=> (opValid && !memReq && extWords == '0));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && rfWrIdx == 4'd0 && rfRdIdx == 4'd0) |-> (rfWrData == rfRdData + DATA_W'(2)));

  // R11
  write_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (memReq && memAck));

  // R11
  valid_when_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> !memReq);
endmodule

bind src_operand_fetch sof_chk #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_sof_chk (
  .clk(clk), .rstN(rstN), .ctlIdle(ctlIdle), .startReq(startReq),
  .srcReg(srcReg), .srcMode(srcMode), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
  .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .memReq(memReq),
  .memAddr(memAddr), .memAck(memAck), .opValid(opValid), .extWords(extWords)
);

// File: tb/test_src_operand_fetch.sv
module test_src_operand_fetch;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] data;
    logic [1:0]  ext;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [3:0]  srcReg = '0;
  logic [1:0]  srcMode = '0;
  logic        byteOp = 1'b0;
  logic [3:0]  rfRdIdx, rfWrIdx;
  logic [15:0] rfRdData, rfWrData, memAddr, memRdata, opData;
  logic        rfWrEn, memReq, memAck, opValid;
  logic [1:0]  extWords;

  logic [15:0] regs [16];
  logic        loadEn = 1'b0;
  logic [3:0]  loadIdx = '0;
  logic [15:0] loadVal = '0;
  int          waitStates = 0;
  int          ackCnt;

  logic [15:0] expRegs [16];
  exp_t        sbq[$];
  int          vectors = 0;
  int          miscompares = 0;
  int          doneCnt = 0;
  int          issued = 0;
  int          memCycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  src_operand_fetch i_src_operand_fetch (
    .clk(clk), .rstN(rstN), .startReq(startReq), .srcReg(srcReg),
    .srcMode(srcMode), .byteOp(byteOp), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .memReq(memReq),
    .memAddr(memAddr), .memRdata(memRdata), .memAck(memAck), .opValid(opValid),
    .opData(opData), .extWords(extWords)
  );

  function automatic logic [15:0] memWord(input logic [15:0] a);
    logic [7:0] w;
    w = a[8:1];
    return {w ^ 8'hA5, ~w};
  endfunction

  function automatic logic [15:0] readModel(input logic [15:0] a, input logic b);
    logic [15:0] w;
    w = memWord(a);
    if (!b) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  assign rfRdData = regs[rfRdIdx];
  assign memRdata = memWord(memAddr);
  assign memAck   = memReq && (ackCnt >= waitStates);

  always_ff @(posedge clk) begin
    if (!memReq || memAck) ackCnt <= 0;
    else                   ackCnt <= ackCnt + 1;
    if (loadEn)      regs[loadIdx] <= loadVal;
    else if (rfWrEn) regs[rfWrIdx] <= rfWrData;
  end

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Monitor: compare each completed operand against the scoreboard
  always @(negedge clk) begin
    if (rstN && memReq) begin
      memCycles++;
      check("R9", "memAddr bit0", {15'd0, memAddr[0]}, 16'd0);
    end
    if (rstN && opValid) begin
      if (sbq.size() == 0) begin
        check("R11", "unexpected opValid", 16'd1, 16'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, "opData", opData, e.data);
        check(e.tag, "extWords", {14'd0, extWords}, {14'd0, e.ext});
      end
      doneCnt++;
    end
  end

  task automatic setReg(input logic [3:0] idx, input logic [15:0] val);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadVal = val;
    @(negedge clk);
    loadEn = 1'b0;
    expRegs[idx] = val;
  endtask

  task automatic issue(input logic [3:0] r, input logic [1:0] m, input logic b, input string tag, input bool_direct = 0);
    exp_t e;
    logic [15:0] pc, v, addr, ext, base;
    logic [1:0]  extN;
    logic        direct;
    pc = expRegs[0];
    extN = 2'd0;
    direct = 1'b0;
    if (r == 4'd3) begin
      direct = 1'b1;
      case (m)
        2'd0: v = 16'h0000;
        2'd1: v = 16'h0001;
        2'd2: v = 16'h0002;
        default: v = 16'hFFFF;
      endcase
    end else if (r == 4'd2 && m[1]) begin
      direct = 1'b1;
      v = m[0] ? 16'h0008 : 16'h0004;
    end else begin
      case (m)
        2'd0: begin direct = 1'b1; v = expRegs[r]; end
        2'd1: begin
          ext = memWord(pc);
          expRegs[0] = pc + 16'd2;
          if (r == 4'd0)      base = pc;
          else if (r == 4'd2) base = 16'h0000;
          else                base = expRegs[r];
          addr = ext + base;
          v = readModel(addr, b);
          extN = 2'd1;
        end
        2'd2: begin addr = expRegs[r]; v = readModel(addr, b); end
        default: begin
          addr = expRegs[r];
          v = readModel(addr, b);
          expRegs[r] = addr + ((b && r != 4'd0) ? 16'd1 : 16'd2);
          extN = (r == 4'd0) ? 2'd1 : 2'd0;
        end
      endcase
    end
    if (direct && b) v = {8'h00, v[7:0]};
    e.data = v; e.ext = extN; e.tag = tag;
    sbq.push_back(e);
    issued++;
    @(negedge clk);
    memCycles = 0;
    startReq = 1'b1; srcReg = r; srcMode = m; byteOp = b;
    @(negedge clk);
    startReq = 1'b0;
    wait (doneCnt == issued);
    if (direct) check(tag, "memory cycles", 16'(memCycles), 16'd0);
    check(tag, "PC after", regs[0], expRegs[0]);
    check(tag, "source reg after", regs[r], expRegs[r]);
    @(negedge clk);
    check("R11", "opValid pulse width", {15'd0, opValid}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R11 watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      regs[i] = '0;
      expRegs[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "reset opValid", {15'd0, opValid}, 16'd0);
    check("R11", "reset memReq", {15'd0, memReq}, 16'd0);
    check("R11", "reset rfWrEn", {15'd0, rfWrEn}, 16'd0);

    setReg(4'd0, 16'h0100);
    setReg(4'd1, 16'h0010);
    setReg(4'd2, 16'h0107);
    setReg(4'd4, 16'h1234);
    setReg(4'd5, 16'h0031);
    setReg(4'd6, 16'h0040);
    setReg(4'd7, 16'h00FE);

    issue(4'd4, 2'd0, 1'b0, "R1");
    issue(4'd4, 2'd0, 1'b1, "R10");
    issue(4'd2, 2'd0, 1'b0, "R1");
    issue(4'd3, 2'd0, 1'b0, "R2");
    issue(4'd3, 2'd1, 1'b0, "R2");
    issue(4'd3, 2'd2, 1'b0, "R2");
    issue(4'd3, 2'd3, 1'b0, "R2");
    issue(4'd2, 2'd2, 1'b0, "R2");
    issue(4'd2, 2'd3, 1'b0, "R2");
    issue(4'd3, 2'd3, 1'b1, "R10");
    issue(4'd6, 2'd1, 1'b0, "R3");
    issue(4'd1, 2'd1, 1'b1, "R3");
    issue(4'd0, 2'd1, 1'b0, "R4");
    issue(4'd2, 2'd1, 1'b0, "R5");
    issue(4'd2, 2'd1, 1'b1, "R5");
    issue(4'd5, 2'd2, 1'b0, "R6");
    issue(4'd5, 2'd2, 1'b1, "R9");
    issue(4'd6, 2'd2, 1'b1, "R9");
    issue(4'd7, 2'd3, 1'b0, "R7");
    issue(4'd5, 2'd3, 1'b1, "R7");
    issue(4'd5, 2'd3, 1'b1, "R7");
    issue(4'd0, 2'd3, 1'b0, "R8");
    issue(4'd0, 2'd3, 1'b1, "R8");

    waitStates = 2;
    issue(4'd6, 2'd1, 1'b0, "R11");
    issue(4'd7, 2'd3, 1'b1, "R11");
    issue(4'd0, 2'd3, 1'b0, "R11");
    issue(4'd4, 2'd2, 1'b0, "R11");
    waitStates = 0;

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule